// File: doc/BRIEF.md
# GPIO Interrupt Detection Controller

This block is the interrupt front end of a general-purpose I/O unit. It watches 32 input pads and brings each one into the clock domain through a two-stage synchroniser. Each pin is then classified as either level-sensitive or edge-sensitive. A level pin has a chosen active polarity. An edge pin has independent enables for the rising and the falling edge. Every pin has a pending status bit that either latches an event until software clears it (hold) or follows the detector every cycle (through). A per-pin enable mask gates the pending bits into a single interrupt line, which feeds a cascaded interrupt controller.

Software reaches the block through a 16-bit register port with a write strobe, a 4-bit register index and a combinational read-back. Each 32-bit quantity is split over a low half (pins 0..15, bit = pin) and a high half (pins 16..31, bit = pin - 16). A status write clears the bits written as one and leaves the bits written as zero untouched. Masking a pin hides its pending status from the interrupt line but does not discard it.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is asserted and until the first update after the internal reset release, every register reads 0 and `irq_out` is low. Reset is asynchronous on `rst_n` and is released through two flops, so the first functional update is the third rising edge after `rst_n` goes high.
- R2: Register index bit 0 selects the half (0 = pins 0..15, 1 = pins 16..31) and bits 3:1 select the register: 0 status, 1 enable, 2 type, 3 polarity, 4 hold, 5 falling-edge enable, 6 rising-edge enable. Configuration registers read back what was written. Index 14 and 15 read 0, and writes to them change nothing.
- R3: A pad change is seen by detection only after two synchroniser flops. A through-mode level pin's status reflects a pad change after the third rising edge. An edge is found by comparing the synchronised sample with the sample one cycle older.
- R4: A type bit of 0 selects level detection. A level pin is active when its synchronised input equals its polarity bit (1 = active high, 0 = active low).
- R5: A type bit of 1 selects edge detection. A rising edge counts only when the rising enable is 1, and a falling edge counts only when the falling enable is 1. With both set, either edge counts. With neither set, the pin never raises an event.
- R6: With the hold bit set, a detected event sets the status bit, and the bit stays set until a status write with a 1 in that position. Writing 0 has no effect.
- R7: With the hold bit clear, the status bit equals the detector output of the previous cycle. A level pin follows its qualified level, and an edge pin gives a one-cycle pulse. Status writes have no lasting effect.
- R8: When a detected event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq_out` is high exactly when some bit is set in both status and enable, in either half. Clearing an enable bit removes the pin from `irq_out` but keeps its status bit.
- R10: The polarity bit has no effect on an edge pin, and the edge enables have no effect on a level pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 2*DW | Asynchronous pad inputs, one bit per pin |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 4 | Register index (bit 0 half, bits 3:1 register) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Cascade interrupt, OR of status AND enable |

## Verification
The two functions that can fall in the same cycle are the hardware setting a status bit and a software write clearing it. The bench holds level pins active in hold mode while it repeatedly writes ones to the status register. It also moves a pad edge against a clearing write with delays of zero to three cycles, so that the detection edge lands before, on and after the write. A behavioural model in the bench predicts every status bit each cycle with the set taking precedence. Read-back and the interrupt line are compared with the model on every falling edge.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  localparam int DW_DEF = 16;
  localparam int AW     = 4;
  localparam int NCFG   = 6;

  // register select, taken from index bits 3:1
  typedef enum logic [2:0] {
    F_STAT  = 3'd0,
    F_MASK  = 3'd1,
    F_KIND  = 3'd2,
    F_POL   = 3'd3,
    F_LATCH = 3'd4,
    F_FALL  = 3'd5,
    F_RISE  = 3'd6,
    F_NONE  = 3'd7
  } field_e;

  // slots in the configuration array (field code minus one)
  localparam int C_MASK  = 0;
  localparam int C_KIND  = 1;
  localparam int C_POL   = 2;
  localparam int C_LATCH = 3;
  localparam int C_FALL  = 4;
  localparam int C_RISE  = 5;

endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st1_q, st2_q;
  logic [W-1:0] st1_d, st2_d;

  always_comb begin
    st1_d = d;
    st2_d = st1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= st1_d;
      st2_q <= st2_d;
    end
  end

  assign q = st2_q;

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
  parameter int NP = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] smp,
  input  logic [NP-1:0] kind,
  input  logic [NP-1:0] pol,
  input  logic [NP-1:0] rise_en,
  input  logic [NP-1:0] fall_en,
  output logic [NP-1:0] hit
);

  logic [NP-1:0] prev_q, prev_d;

  always_comb prev_d = smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < NP; i++) begin : g_pin
    logic up, dn, lvl, evt;
    assign up  = smp[i] & ~prev_q[i];
    assign dn  = ~smp[i] & prev_q[i];
    assign lvl = ~(smp[i] ^ pol[i]);
    assign evt = (up & rise_en[i]) | (dn & fall_en[i]);
    assign hit[i] = kind[i] ? evt : lvl;
  end

  // edge pins with both enables off must stay silent
  AST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & kind & ~(rise_en | fall_en)) == '0));  // R5

  // a level pin hits exactly when the sample matches its polarity
  AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & ~kind) == (~(smp ^ pol) & ~kind)));  // R4

endmodule

// File: rtl/gpio_irq_cfg.sv
`timescale 1ns/1ps
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int DW = 16,
  parameter int NP = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NP-1:0] hit,
  output logic [NP-1:0] enable,
  output logic [NP-1:0] kind,
  output logic [NP-1:0] pol,
  output logic [NP-1:0] latch,
  output logic [NP-1:0] fall_en,
  output logic [NP-1:0] rise_en,
  output logic [NP-1:0] status,
  output logic [DW-1:0] rdata
);

  logic [NCFG-1:0][NP-1:0] cfg_q, cfg_d;
  logic [NP-1:0]           stat_q, stat_d;
  logic [NP-1:0]           clr;
  logic                    cfg_en;
  field_e                  fld;
  logic                    half;
  int                      base;
  int                      slot;

  assign fld  = field_e'(addr[3:1]);
  assign half = addr[0];
  assign base = half ? DW : 0;
  assign slot = int'(fld) - 1;

  // next-state for configuration and clear vector
  always_comb begin
    cfg_d  = cfg_q;
    clr    = '0;
    cfg_en = 1'b0;
    if (wr) begin
      if (fld == F_STAT) begin
        clr[base +: DW] = wdata;
      end else if (fld != F_NONE) begin
        cfg_en = 1'b1;
        cfg_d[slot][base +: DW] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign enable  = cfg_q[C_MASK];
  assign kind    = cfg_q[C_KIND];
  assign pol     = cfg_q[C_POL];
  assign latch   = cfg_q[C_LATCH];
  assign fall_en = cfg_q[C_FALL];
  assign rise_en = cfg_q[C_RISE];

  // status: held bits survive unless cleared, the detector sets and wins
  always_comb stat_d = (stat_q & ~clr & latch) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign status = stat_q;

  // read mux
  logic [NP-1:0] rsel;
  always_comb begin
    case (fld)
      F_STAT:  rsel = stat_q;
      F_NONE:  rsel = '0;
      default: rsel = cfg_q[slot];
    endcase
    rdata = half ? rsel[NP-1:DW] : rsel[DW-1:0];
  end

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & latch & ~clr)) |=>
      ((stat_q & $past(stat_q & latch & ~clr)) == $past(stat_q & latch & ~clr)));  // R6

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & clr)) |=> ((stat_q & $past(hit & clr)) == $past(hit & clr)));  // R8

  AST_THROUGH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~latch)) |=> ((stat_q & ~$past(latch)) == ($past(hit) & ~$past(latch))));  // R7

  AST_RSVD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && fld == F_NONE) |=> $stable(cfg_q));  // R2

endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int DW = DW_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*DW-1:0] pad_in,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_out
);

  localparam int NP = 2 * DW;

  // asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic [NP-1:0] smp, hit;
  logic [NP-1:0] enable, kind, pol, latch, fall_en, rise_en, status;

  gpio_irq_sync #(.W(NP)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     (pad_in),
    .q     (smp)
  );

  gpio_irq_detect #(.NP(NP)) u_detect (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .smp     (smp),
    .kind    (kind),
    .pol     (pol),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .hit     (hit)
  );

  gpio_irq_cfg #(.DW(DW), .NP(NP)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .hit     (hit),
    .enable  (enable),
    .kind    (kind),
    .pol     (pol),
    .latch   (latch),
    .fall_en (fall_en),
    .rise_en (rise_en),
    .status  (status),
    .rdata   (reg_rdata)
  );

  assign irq_out = |(status & enable);

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    (enable == '0) |-> !irq_out);  // R9

  AST_RESET_IDLE: assert property (@(posedge clk)
    (!rst_i_n) |-> (!irq_out && status == '0));  // R1

endmodule

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pad_in;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq_out;

  int    n_cmp  = 0;
  int    n_bad  = 0;
  string cur_req = "R1";
  bit    done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_in    (pad_in),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_s1 = 0, m_s2 = 0, m_prev = 0, m_stat = 0;
  logic [31:0] m_en = 0, m_kind = 0, m_pol = 0, m_hold = 0, m_fall = 0, m_rise = 0;
  logic [31:0] m_next;
  int          m_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0;
      {m_s1, m_s2, m_prev, m_stat} = '0;
      {m_en, m_kind, m_pol, m_hold, m_fall, m_rise} = '0;
    end else if (m_cnt < 2) begin
      m_cnt = m_cnt + 1;
    end else begin
      for (int i = 0; i < 32; i++) begin
        bit s, p, h, c;
        s = m_s2[i];
        p = m_prev[i];
        if (m_kind[i]) h = (m_rise[i] && s && !p) || (m_fall[i] && !s && p);
        else           h = (s == m_pol[i]);
        c = reg_wr && (reg_addr[3:1] == 3'd0) && (reg_addr[0] == (i / 16))
            && reg_wdata[i % 16];
        if (h)              m_next[i] = 1'b1;
        else if (!m_hold[i]) m_next[i] = 1'b0;
        else if (c)         m_next[i] = 1'b0;
        else                m_next[i] = m_stat[i];
      end
      if (reg_wr) begin
        int b;
        b = reg_addr[0] ? 16 : 0;
        case (reg_addr[3:1])
          3'd1: m_en[b +: 16]   = reg_wdata;
          3'd2: m_kind[b +: 16] = reg_wdata;
          3'd3: m_pol[b +: 16]  = reg_wdata;
          3'd4: m_hold[b +: 16] = reg_wdata;
          3'd5: m_fall[b +: 16] = reg_wdata;
          3'd6: m_rise[b +: 16] = reg_wdata;
          default: ;
        endcase
      end
      m_stat = m_next;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pad_in;
    end
  end

  function automatic logic [15:0] exp_read(input logic [3:0] a);
    logic [31:0] v;
    case (a[3:1])
      3'd0: v = m_stat;
      3'd1: v = m_en;
      3'd2: v = m_kind;
      3'd3: v = m_pol;
      3'd4: v = m_hold;
      3'd5: v = m_fall;
      3'd6: v = m_rise;
      default: v = '0;
    endcase
    return a[0] ? v[31:16] : v[15:0];
  endfunction

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      logic [15:0] er;
      logic        ei;
      er = exp_read(reg_addr);
      ei = |(m_stat & m_en);
      n_cmp = n_cmp + 2;
      if (reg_rdata !== er) begin
        n_bad = n_bad + 1;
        $display("FAIL %s: read index %0d actual %h expected %h at %0t",
                 cur_req, reg_addr, reg_rdata, er, $time);
      end
      if (irq_out !== ei) begin
        n_bad = n_bad + 1;
        $display("FAIL %s: irq_out actual %b expected %b at %0t",
                 cur_req, irq_out, ei, $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [3:0] sweep = 0;

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      reg_addr = sweep;
      sweep    = sweep + 1;
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic wide(input logic [2:0] f, input logic [31:0] v);
    wreg({f, 1'b0}, v[15:0]);
    wreg({f, 1'b1}, v[31:16]);
  endtask

  task automatic cfg_all(input logic [31:0] en, kind, pol, hold, fall, rise);
    wide(3'd1, en);   wide(3'd2, kind); wide(3'd3, pol);
    wide(3'd4, hold); wide(3'd5, fall); wide(3'd6, rise);
  endtask

  task automatic setpad(input logic [31:0] v);
    @(negedge clk); #1;
    pad_in = v;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  logic [31:0] rnd = 32'h1234_5679;

  task automatic rnd_pads(input int n, input int gap);
    for (int k = 0; k < n; k++) begin
      rnd = nxt(rnd);
      setpad(rnd);
      idle(gap);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done  = 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0; pad_in = 32'hFFFF_FFFF;
    reg_wr = 1'b0; reg_addr = 4'd0; reg_wdata = 16'd0;

    // R1: everything zero in reset and across the release window
    cur_req = "R1";
    idle(18);
    @(negedge clk); #1; rst_n = 1'b1;
    idle(20);

    // R2: read-back of every configuration half, reserved indices inert
    cur_req = "R2";
    for (int f = 1; f <= 6; f++) begin
      wreg(4'(f * 2),     16'hA5C3 ^ 16'(f * 16'h1111));
      wreg(4'(f * 2 + 1), 16'h3C5A ^ 16'(f * 16'h0707));
    end
    idle(16);
    wreg(4'd14, 16'hFFFF);
    wreg(4'd15, 16'hFFFF);
    idle(16);

    // R3, R4: level pins, mixed polarity, through mode
    cur_req = "R4";
    cfg_all(32'hFFFF_FFFF, 32'h0, 32'h0F0F_F0F0, 32'h0, 32'h0, 32'h0);
    rnd_pads(12, 4);
    cur_req = "R3";
    setpad(32'h0000_0000); idle(1); setpad(32'hFFFF_FFFF); idle(6);

    // R5: edge pins with rising-only, falling-only, both and neither, held
    cur_req = "R5";
    cfg_all(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF,
            32'h0F0F_0F0F, 32'h00FF_00FF);
    wide(3'd0, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) begin
      rnd_pads(2, 3);
      wide(3'd0, 32'hFFFF_FFFF);
      idle(3);
    end

    // R6: held events, partial clears, zero writes
    cur_req = "R6";
    cfg_all(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF,
            32'hFFFF_FFFF, 32'hFFFF_FFFF);
    setpad(32'h0000_0000); idle(5);
    wreg(4'd0, 16'h0000); idle(4);
    wreg(4'd0, 16'h00F0); idle(4);
    wreg(4'd1, 16'h8001); idle(4);
    wreg(4'd1, 16'h0000); idle(4);
    wide(3'd0, 32'hFFFF_FFFF); idle(6);

    // R7: through-mode edge pulses and level following
    cur_req = "R7";
    wide(3'd4, 32'h0000_0000);
    rnd_pads(10, 3);
    wide(3'd2, 32'h0000_FFFF);
    rnd_pads(6, 3);
    wide(3'd0, 32'hFFFF_FFFF); idle(4);

    // R8: event and clear on the same bit in the same cycle
    cur_req = "R8";
    cfg_all(32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0);
    setpad(32'hFFFF_FFFF); idle(4);
    for (int k = 0; k < 4; k++) begin
      wide(3'd0, 32'hFFFF_FFFF);
      idle(2);
    end
    cfg_all(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF,
            32'hFFFF_FFFF, 32'hFFFF_FFFF);
    for (int dly = 0; dly < 4; dly++) begin
      setpad(~pad_in);
      idle(dly);
      wreg(4'd0, 16'hFFFF);
      wreg(4'd1, 16'hFFFF);
      idle(3);
      wide(3'd0, 32'hFFFF_FFFF);
      idle(2);
    end

    // R9: masking keeps pending status
    cur_req = "R9";
    setpad(32'h1234_8765); idle(5);
    wide(3'd1, 32'h0000_0000); idle(8);
    wreg(4'd2, 16'h8765); idle(6);
    wreg(4'd2, 16'h0000); wreg(4'd3, 16'h0010); idle(6);
    wide(3'd0, 32'hFFFF_FFFF); idle(6);

    // R10: polarity on edge pins and edge enables on level pins are inert
    cur_req = "R10";
    cfg_all(32'hFFFF_FFFF, 32'hFFFF_0000, 32'hF0F0_F0F0, 32'hFFFF_FFFF,
            32'h3333_3333, 32'h5555_5555);
    for (int k = 0; k < 6; k++) begin
      rnd_pads(2, 3);
      wide(3'd0, 32'hFFFF_FFFF);
    end
    wide(3'd3, 32'h0F0F_0F0F);
    rnd_pads(6, 3);
    idle(8);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule